// File: doc/BRIEF.md
# Processor Glue Register Bank with Interrupt Steering

This block is a small memory-mapped register bank that sits on a simple byte-addressed bus beside a group of processors. It gives firmware four services: a register that halts the system and passes out an exit code, a read-only register that tells a processor its own index, a read-only register holding the number of processors, and an interrupt register that drives one level-sensitive interrupt line per processor.

The bus is a single-cycle port. A transfer is presented with `bus_valid` high for one clock, with a direction bit, an address, a width code and write data. Only the six lowest address bits select a register, so the bank appears again every 64 bytes. Writes act on the clock edge that samples them. Read data is registered: it appears after that same edge and holds until the next read. A single two-byte store to the interrupt register carries both a line number and a level. The addressed line keeps that level until another store changes it.

Top module: `glue_regbank`

## Requirements
- R1: The register offset is the bus address ANDed with 0x3F. Accesses at addresses that differ only above bit 5 reach the same register.
- R2: Any write at offset 0x00, of any width, pulses `halt_stb` high for exactly one cycle after the sampling edge. On that same edge `halt_code` takes `bus_wdata[7:0]` and holds it.
- R3: A read at offset 0x04 returns `cpu_idx` in `bus_rdata[7:0]`. All other bits are zero.
- R4: A read at offset 0x0A returns the processor count `N_CPU` in `bus_rdata[7:0]` when `COUNT_CFG` is 1. It returns 1 when `COUNT_CFG` is 0.
- R5: A write at offset 0x08 with width code 1 (two bytes) or wider uses `bus_wdata[7:0]` as the line number and `bus_wdata[15:8]` as the level. Line `irq[port]` becomes 1 when the level is nonzero and 0 when it is zero. No other line changes.
- R6: A write at offset 0x08 with width code 0 (one byte) drives level 0 onto the selected line. This clears it whatever `bus_wdata[15:8]` holds.
- R7: Each interrupt line holds its value through reads, halt writes and writes elsewhere, until a write to offset 0x08 selects it.
- R8: An interrupt write whose line number is `N_CPU` or more changes no interrupt line.
- R9: Reads at offsets other than 0x04 and 0x0A return zero. This includes the write-only offsets 0x00 and 0x08. Writes to the read-only offsets change nothing that can be read back.
- R10: During and after reset, before any access, `irq`, `halt_stb`, `halt_code` and `bus_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Transfer present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | Width code: 0 = one byte, 1 = two bytes, 2 or 3 = four bytes |
| bus_wdata | input | 32 | Write data; first byte in [7:0], second byte in [15:8] |
| cpu_idx | input | 8 | Index of the requesting processor |
| bus_rdata | output | 32 | Registered read data, zero-filled |
| irq | output | N_CPU | Level interrupt line per processor |
| halt_stb | output | 1 | One-cycle halt request |
| halt_code | output | 8 | Exit code from the last halt write |

## Verification
The assertions assume that `bus_valid` is a one-cycle strobe and that every bus input is known whenever it is high. They also assume that `rst_n` is held low across at least one rising clock edge before the first access. The bench drives all inputs on the falling edge and keeps `bus_valid` high for exactly one rising edge per transfer. It returns `bus_valid` low between transfers and applies reset before any access, so each property sees only defined, isolated transfers. Line numbers outside the processor range are produced on purpose, but always with a defined width code.

// File: rtl/glue_pkg.sv
package glue_pkg;

  localparam int OFS_W = 6;

  localparam logic [OFS_W-1:0] OFS_HALT    = 6'h00;
  localparam logic [OFS_W-1:0] OFS_CPU_IDX = 6'h04;
  localparam logic [OFS_W-1:0] OFS_IRQ     = 6'h08;
  localparam logic [OFS_W-1:0] OFS_CPU_CNT = 6'h0A;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORD2 = 2'd3
  } bus_size_e;

  // True when the access carries a second byte lane.
  function automatic logic carries_second_byte(input bus_size_e sz);
    return sz != SZ_BYTE;
  endfunction

  // Level requested by an interrupt write; a one-byte store yields zero.
  function automatic logic level_requested(input bus_size_e sz, input logic [15:0] wd);
    if (!carries_second_byte(sz)) return 1'b0;
    return wd[15:8] != 8'h00;
  endfunction

  // Line number lies inside the implemented range.
  function automatic logic port_in_range(input logic [7:0] port, input int n);
    return int'(port) < n;
  endfunction

  // Value reported by the count register.
  function automatic logic [7:0] count_value(input int n, input bit cfg);
    return cfg ? 8'(n) : 8'd1;
  endfunction

  // Zero-filled read word for one offset.
  function automatic logic [31:0] read_word(input logic [OFS_W-1:0] ofs,
                                            input logic [7:0] idx,
                                            input logic [7:0] cnt);
    logic [31:0] w;
    w = '0;
    unique case (ofs)
      OFS_CPU_IDX: w[7:0] = idx;
      OFS_CPU_CNT: w[7:0] = cnt;
      default:     w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/glue_decode.sv
module glue_decode
  import glue_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [15:0]       wdata_lo,
  output logic              halt_wr_evt,
  output logic              irq_wr_evt,
  output logic              rd_evt,
  output logic [OFS_W-1:0]  rd_ofs,
  output logic [7:0]        irq_port,
  output logic              irq_level_on
);

  logic [OFS_W-1:0]        ofs;
  logic [ADDR_W-OFS_W-1:0] unused_addr_hi;
  logic                    wr_evt;

  assign ofs            = bus_addr[OFS_W-1:0];
  assign unused_addr_hi = bus_addr[ADDR_W-1:OFS_W];
  assign wr_evt         = bus_valid && bus_write;

  assign rd_evt       = bus_valid && !bus_write;
  assign rd_ofs       = ofs;
  assign halt_wr_evt  = wr_evt && (ofs == OFS_HALT);
  assign irq_wr_evt   = wr_evt && (ofs == OFS_IRQ);
  assign irq_port     = wdata_lo[7:0];
  assign irq_level_on = level_requested(bus_size_e'(bus_size), wdata_lo);

endmodule

// File: rtl/glue_irq_bank.sv
module glue_irq_bank
  import glue_pkg::*;
#(
  parameter int N_CPU = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_wr_evt,
  input  logic [7:0]       irq_port,
  input  logic             irq_level_on,
  output logic [N_CPU-1:0] irq
);

  logic port_ok;
  assign port_ok = port_in_range(irq_port, N_CPU);

  for (genvar i = 0; i < N_CPU; i++) begin : g_line
    logic hit;
    assign hit = irq_wr_evt && port_ok && (irq_port == 8'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   irq[i] <= 1'b0;
      else if (hit) irq[i] <= irq_level_on;
    end
  end

endmodule

// File: rtl/glue_halt.sv
module glue_halt (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_wr_evt,
  input  logic [7:0] code_in,
  output logic       halt_stb,
  output logic [7:0] halt_code
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_stb  <= 1'b0;
      halt_code <= 8'h00;
    end else begin
      halt_stb <= halt_wr_evt;
      if (halt_wr_evt) halt_code <= code_in;
    end
  end

endmodule

// File: rtl/glue_rdmux.sv
module glue_rdmux
  import glue_pkg::*;
#(
  parameter int N_CPU     = 4,
  parameter bit COUNT_CFG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_evt,
  input  logic [OFS_W-1:0] rd_ofs,
  input  logic [7:0]       cpu_idx,
  output logic [31:0]      rdata
);

  localparam logic [7:0] CNT_VAL = count_value(N_CPU, COUNT_CFG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_evt) rdata <= read_word(rd_ofs, cpu_idx, CNT_VAL);
  end

endmodule

// File: rtl/glue_regbank.sv
module glue_regbank
  import glue_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int N_CPU     = 4,
  parameter bit COUNT_CFG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  input  logic [7:0]        cpu_idx,
  output logic [31:0]       bus_rdata,
  output logic [N_CPU-1:0]  irq,
  output logic              halt_stb,
  output logic [7:0]        halt_code
);

  logic             halt_wr_evt;
  logic             irq_wr_evt;
  logic             rd_evt;
  logic [OFS_W-1:0] rd_ofs;
  logic [7:0]       irq_port;
  logic             irq_level_on;
  logic [15:0]      unused_wdata_hi;

  assign unused_wdata_hi = bus_wdata[31:16];

  glue_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_valid    (bus_valid),
    .bus_write    (bus_write),
    .bus_addr     (bus_addr),
    .bus_size     (bus_size),
    .wdata_lo     (bus_wdata[15:0]),
    .halt_wr_evt  (halt_wr_evt),
    .irq_wr_evt   (irq_wr_evt),
    .rd_evt       (rd_evt),
    .rd_ofs       (rd_ofs),
    .irq_port     (irq_port),
    .irq_level_on (irq_level_on)
  );

  glue_irq_bank #(.N_CPU(N_CPU)) u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_wr_evt   (irq_wr_evt),
    .irq_port     (irq_port),
    .irq_level_on (irq_level_on),
    .irq          (irq)
  );

  glue_halt u_halt (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt_wr_evt (halt_wr_evt),
    .code_in     (bus_wdata[7:0]),
    .halt_stb    (halt_stb),
    .halt_code   (halt_code)
  );

  glue_rdmux #(.N_CPU(N_CPU), .COUNT_CFG(COUNT_CFG)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_evt  (rd_evt),
    .rd_ofs  (rd_ofs),
    .cpu_idx (cpu_idx),
    .rdata   (bus_rdata)
  );

endmodule

// File: rtl/glue_regbank_chk.sv
module glue_regbank_chk #(
  parameter int N_CPU = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             halt_wr_evt,
  input logic             irq_wr_evt,
  input logic [7:0]       irq_port,
  input logic [N_CPU-1:0] irq,
  input logic             halt_stb,
  input logic [31:0]      rdata
);

  assert_halt_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    halt_wr_evt |=> halt_stb);

  assert_halt_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_wr_evt |=> !halt_stb);

  assert_one_line_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq ^ $past(irq)) <= 1);

  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_wr_evt |=> $stable(irq));

  assert_bad_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_wr_evt && (int'(irq_port) >= N_CPU)) |=> $stable(irq));

  assert_rdata_narrow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[31:8] == 24'h0);

endmodule

bind glue_regbank glue_regbank_chk #(.N_CPU(N_CPU)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .halt_wr_evt (halt_wr_evt),
  .irq_wr_evt  (irq_wr_evt),
  .irq_port    (irq_port),
  .irq         (irq),
  .halt_stb    (halt_stb),
  .rdata       (bus_rdata)
);

// File: tb/glue_regbank_tb.sv
`timescale 1ns/1ps
module glue_regbank_tb;

  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [7:0]  cpu_idx = '0;
  logic [31:0] bus_rdata, rdata_nc;
  logic [N-1:0] irq, irq_nc;
  logic        halt_stb, halt_stb_nc;
  logic [7:0]  halt_code, halt_code_nc;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  glue_regbank #(.ADDR_W(32), .N_CPU(N), .COUNT_CFG(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .cpu_idx(cpu_idx), .bus_rdata(bus_rdata), .irq(irq),
    .halt_stb(halt_stb), .halt_code(halt_code));

  glue_regbank #(.ADDR_W(32), .N_CPU(N), .COUNT_CFG(1'b0)) u_dut_nocfg (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .cpu_idx(cpu_idx), .bus_rdata(rdata_nc), .irq(irq_nc),
    .halt_stb(halt_stb_nc), .halt_code(halt_code_nc));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // One transfer; returns at the falling edge after the sampling edge.
  task automatic xfer(input bit wr, input logic [31:0] a, input logic [1:0] sz,
                      input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic t_reset;
    check("R10 irq", 32'(irq), 32'h0);
    check("R10 halt_stb", 32'(halt_stb), 32'h0);
    check("R10 halt_code", 32'(halt_code), 32'h0);
    check("R10 rdata", bus_rdata, 32'h0);
  endtask

  task automatic t_irq_set;
    xfer(1, 32'h08, 2'd1, 32'h0000_0102);
    check("R5 0x0102 sets line 2", 32'(irq), 32'h4);
    xfer(1, 32'h08, 2'd2, 32'h0000_3700);
    check("R5 word write sets line 0", 32'(irq), 32'h5);
    xfer(1, 32'h08, 2'd1, 32'h0000_0000);
    check("R5 level 0 clears line 0", 32'(irq), 32'h4);
    xfer(1, 32'h08, 2'd1, 32'h0000_8003);
    check("R5 sets line 3", 32'(irq), 32'hC);
  endtask

  task automatic t_irq_byte;
    xfer(1, 32'h08, 2'd0, 32'h0000_FF02);
    check("R6 byte write clears line 2", 32'(irq), 32'h8);
    xfer(1, 32'h08, 2'd0, 32'h0000_0101);
    check("R6 byte write leaves line 1 low", 32'(irq), 32'h8);
  endtask

  task automatic t_hold;
    xfer(0, 32'h04, 2'd0, 32'h0);
    xfer(1, 32'h10, 2'd1, 32'h0000_0103);
    xfer(1, 32'h00, 2'd0, 32'h0000_0000);
    repeat (3) @(negedge clk);
    check("R7 line 3 holds", 32'(irq), 32'h8);
  endtask

  task automatic t_bad_port;
    xfer(1, 32'h08, 2'd1, 32'h0000_0104);
    check("R8 port N ignored", 32'(irq), 32'h8);
    xfer(1, 32'h08, 2'd1, 32'h0000_00FF);
    check("R8 port 0xFF ignored", 32'(irq), 32'h8);
  endtask

  task automatic t_halt;
    xfer(1, 32'h00, 2'd2, 32'h1234_56A5);
    check("R2 halt_stb high", 32'(halt_stb), 32'h1);
    check("R2 halt_code", 32'(halt_code), 32'hA5);
    @(negedge clk);
    check("R2 halt_stb one cycle", 32'(halt_stb), 32'h0);
    check("R2 halt_code held", 32'(halt_code), 32'hA5);
  endtask

  task automatic t_alias;
    xfer(1, 32'h0000_1048, 2'd1, 32'h0000_0101);
    check("R1 aliased irq write", 32'(irq), 32'hA);
    xfer(1, 32'hFFFF_FFC0, 2'd0, 32'h0000_003C);
    check("R1 aliased halt write", 32'(halt_code), 32'h3C);
    cpu_idx = 8'd2;
    xfer(0, 32'h0000_0444, 2'd0, 32'h0);
    check("R1 aliased index read", bus_rdata, 32'h2);
  endtask

  task automatic t_index_count;
    cpu_idx = 8'd3;
    xfer(0, 32'h04, 2'd0, 32'h0);
    check("R3 index 3", bus_rdata, 32'h3);
    cpu_idx = 8'd1;
    xfer(0, 32'h04, 2'd0, 32'h0);
    check("R3 index 1", bus_rdata, 32'h1);
    xfer(0, 32'h0A, 2'd0, 32'h0);
    check("R4 count configured", bus_rdata, 32'(N));
    check("R4 count default 1", rdata_nc, 32'h1);
  endtask

  task automatic t_unmapped;
    xfer(1, 32'h04, 2'd2, 32'hFFFF_FFFF);
    xfer(0, 32'h04, 2'd0, 32'h0);
    check("R9 write to index ignored", bus_rdata, 32'h1);
    xfer(1, 32'h0A, 2'd2, 32'hFFFF_FFFF);
    xfer(0, 32'h0A, 2'd0, 32'h0);
    check("R9 write to count ignored", bus_rdata, 32'(N));
    xfer(0, 32'h00, 2'd2, 32'h0);
    check("R9 halt offset reads 0", bus_rdata, 32'h0);
    xfer(0, 32'h08, 2'd2, 32'h0);
    check("R9 irq offset reads 0", bus_rdata, 32'h0);
    xfer(0, 32'h3C, 2'd2, 32'h0);
    check("R9 offset 0x3C reads 0", bus_rdata, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_irq_set;
    t_irq_byte;
    t_hold;
    t_bad_port;
    t_halt;
    t_alias;
    t_index_count;
    t_unmapped;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule